// File: doc/BRIEF.md
# State-Space Feedback Control Engine

This block advances a discrete linear controller by one time step each time it is triggered. From the present state vector S (N words) and a freshly sampled pair of plant inputs x, it forms the controller outputs y = C·S + D·x and the next state S' = A·S + B·x. It treats every coefficient matrix as dense and does the products one at a time on a single multiply-accumulate lane. The number of cycles per step depends only on N, so a host timer can pace the loop with a static schedule.

Coefficients live outside the block in storage the datapath only reads. The engine drives a word address and takes the signed word back in the same cycle. The state is held in two banks. A step reads only the active bank and writes S' into the other one. When the last S' word is written, the roles of the two banks swap. No value is ever copied between the banks.

Work is ordered by a three-state sequencer. IDLE waits for a start pulse and moves to ISSUE when one arrives. ISSUE steps through every (row, column) product, one per clock, and moves to DRAIN after the final product is issued. DRAIN waits for the pipeline to empty and returns to IDLE on the final write-back. Behind the sequencer is a six-stage pipeline: issue, operand fetch, multiply, accumulate, scale-and-saturate, write-back. The last four of these stages do the arithmetic.

Top module: `ssc_engine`

## Requirements
- R1: One step yields y = C·S + D·x and S' = A·S + B·x. The coefficient word at address row·(N+2)+col multiplies operand col. Columns 0..N-1 select S[0..N-1], column N selects x0 and column N+1 selects x1. Rows 0 and 1 produce y0 and y1; rows 2..N+1 produce S'[0..N-1]. Word k of a packed vector sits at bits [k·DW +: DW].
- R2: Coefficients are signed with FRAC fraction bits and data are signed integers. Products are summed exactly in a 40-bit accumulator. The sum is shifted right arithmetically by FRAC, which rounds toward minus infinity, and is then clamped to the signed DW-bit range instead of wrapping.
- R3: y is computed from the state S as it was before the step, not from S'.
- R4: `done` becomes visible exactly (N+2)²+4 clock cycles after the edge that accepts `start`, whatever the data are.
- R5: `done` is a single-cycle pulse. In that same cycle `state_out` first shows S'.
- R6: `state_out` shows S unchanged for the whole step until `done`.
- R7: A `start` that arrives while a step is running is ignored: the step's result and latency are unchanged. It sets `overrun`, which stays high until the next accepted `start` clears it.
- R8: After reset, `y_out`, `state_out`, `done` and `overrun` are all zero.
- R9: `x_in` is sampled on the accepting edge. Changes to `x_in` later in the step have no effect on the result.
- R10: A `start` given in the cycle where `done` is high is accepted and begins the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Step trigger, sampled on the rising edge |
| x_in | input | 2*DW | Input samples x1:x0, each signed |
| coef_addr | output | CAW | Coefficient word address, row·(N+2)+col |
| coef_data | input | CW | Coefficient word for coef_addr, returned in the same cycle |
| y_out | output | 2*DW | Output vector y1:y0, each signed |
| state_out | output | N*DW | Contents of the active state bank |
| done | output | 1 | One-cycle pulse at the end of a step |
| overrun | output | 1 | Sticky flag: a start arrived while the engine was busy |

## Verification
Most internal faults show up at the end of a single step. A wrong operand column, a mistaken accumulator clear or a wrong bank select changes the y or S' words that are compared at `done`, which comes (N+2)²+4 cycles after start. A flaw in the bank swap becomes visible one step later instead, because the next step then reads stale or partial state. A mid-step look at `state_out` catches a write into the active bank within the step itself. A broken sequencer shows directly in the `done` latency. A faulty busy decode shows either as an `overrun` error or as a second step starting in the middle of a run.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter  int N  = 4,
    localparam int IW = $clog2(N + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wb_final,
    output logic          busy,
    output logic          accept,
    output logic          iss_v,
    output logic [IW-1:0] iss_row,
    output logic [IW-1:0] iss_col,
    output logic          iss_first,
    output logic          iss_last
);
    localparam logic [IW-1:0] LASTI = IW'(N + 1);

    seq_state_e state_q, state_d;
    logic       issue_end;

    assign issue_end = iss_v && (iss_row == LASTI) && (iss_col == LASTI);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            SEQ_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    accept  = 1'b1;
                    state_d = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: if (issue_end) state_d = SEQ_DRAIN;
            SEQ_DRAIN: if (wb_final)  state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_v   <= 1'b0;
            iss_row <= '0;
            iss_col <= '0;
        end else if (accept) begin
            iss_v   <= 1'b1;
            iss_row <= '0;
            iss_col <= '0;
        end else if (iss_v) begin
            if (iss_col == LASTI) begin
                iss_col <= '0;
                if (iss_row == LASTI) iss_v <= 1'b0;
                else                  iss_row <= iss_row + 1'b1;
            end else begin
                iss_col <= iss_col + 1'b1;
            end
        end
    end

    assign iss_first = (iss_col == '0);
    assign iss_last  = (iss_col == LASTI);

    // R1
    issue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_v |-> (iss_row <= LASTI) && (iss_col <= LASTI));

    // R4
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DRAIN) |-> !iss_v);
endmodule

// File: rtl/ssc_state_banks.sv
module ssc_state_banks #(
    parameter  int N  = 4,
    parameter  int DW = 16,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            flip,
    output logic            act_bank,
    output logic [N*DW-1:0] state_flat
);
    logic [DW-1:0] mem [2][N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_bank <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < N; i++)
                    mem[b][i] <= '0;
        end else begin
            if (wr_en) mem[~act_bank][wr_idx] <= wr_data;
            if (flip)  act_bank <= ~act_bank;
        end
    end

    assign rd_data = mem[act_bank][rd_idx];

    for (genvar g = 0; g < N; g++) begin : g_view
        assign state_flat[g*DW +: DW] = mem[act_bank][g];
    end

    // R6
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flip |=> $stable(state_flat));
endmodule

// File: rtl/ssc_mac_pipe.sv
module ssc_mac_pipe #(
    parameter  int N    = 4,
    parameter  int DW   = 16,
    parameter  int CW   = 16,
    parameter  int AW   = 40,
    parameter  int FRAC = 8,
    localparam int IW   = $clog2(N + 2),
    localparam int PW   = DW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_v,
    input  logic [IW-1:0]        iss_row,
    input  logic                 iss_first,
    input  logic                 iss_last,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] opnd,
    output logic                 wb_v,
    output logic [IW-1:0]        wb_row,
    output logic [DW-1:0]        wb_val
);
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    // stage 2: operand fetch
    logic                 s2_v, s2_first, s2_last;
    logic [IW-1:0]        s2_row;
    logic signed [CW-1:0] s2_coef;
    logic signed [DW-1:0] s2_opnd;
    // stage 3: multiply
    logic                 s3_v, s3_first, s3_last;
    logic [IW-1:0]        s3_row;
    logic signed [PW-1:0] s3_prod;
    // stage 4: accumulate
    logic                 s4_done;
    logic [IW-1:0]        s4_row;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;
    logic [DW-1:0]        sat_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0; s2_row <= '0;
            s2_coef <= '0; s2_opnd <= '0;
            s3_v <= 1'b0; s3_first <= 1'b0; s3_last <= 1'b0; s3_row <= '0;
            s3_prod <= '0;
            s4_done <= 1'b0; s4_row <= '0; acc <= '0;
            wb_v <= 1'b0; wb_row <= '0; wb_val <= '0;
        end else begin
            s2_v     <= iss_v;
            s2_first <= iss_first;
            s2_last  <= iss_last;
            s2_row   <= iss_row;
            s2_coef  <= coef;
            s2_opnd  <= opnd;

            s3_v     <= s2_v;
            s3_first <= s2_first;
            s3_last  <= s2_last;
            s3_row   <= s2_row;
            s3_prod  <= s2_coef * s2_opnd;

            if (s3_v) begin
                if (s3_first) acc <= {{(AW-PW){s3_prod[PW-1]}}, s3_prod};
                else          acc <= acc + {{(AW-PW){s3_prod[PW-1]}}, s3_prod};
            end
            s4_done <= s3_v && s3_last;
            s4_row  <= s3_row;

            wb_v   <= s4_done;
            wb_row <= s4_row;
            if (s4_done) wb_val <= sat_val;
        end
    end

    always_comb begin
        scaled = acc >>> FRAC;
        if (scaled > SAT_HI)      sat_val = {1'b0, {(DW-1){1'b1}}};
        else if (scaled < SAT_LO) sat_val = {1'b1, {(DW-1){1'b0}}};
        else                      sat_val = scaled[DW-1:0];
    end

    // R2
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s4_done && ((acc >>> FRAC) > SAT_HI)) |=> (wb_val == {1'b0, {(DW-1){1'b1}}}));

    // R2
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s4_done && ((acc >>> FRAC) < SAT_LO)) |=> (wb_val == {1'b1, {(DW-1){1'b0}}}));
endmodule

// File: rtl/ssc_engine.sv
module ssc_engine
    import ssc_pkg::*;
#(
    parameter  int N    = 4,
    parameter  int DW   = 16,
    parameter  int CW   = 16,
    parameter  int AW   = 40,
    parameter  int FRAC = 8,
    localparam int CAW  = $clog2((N + 2) * (N + 2))
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*DW-1:0] x_in,
    output logic [CAW-1:0]  coef_addr,
    input  logic [CW-1:0]   coef_data,
    output logic [2*DW-1:0] y_out,
    output logic [N*DW-1:0] state_out,
    output logic            done,
    output logic            overrun
);
    localparam int IW      = $clog2(N + 2);
    localparam int SW      = (N > 1) ? $clog2(N) : 1;
    localparam int LATENCY = (N + 2) * (N + 2) + 4;
    localparam logic [IW-1:0] LASTI = IW'(N + 1);

    logic          busy, accept, iss_v, iss_first, iss_last;
    logic [IW-1:0] iss_row, iss_col;
    logic          wb_v, wb_final, act_bank;
    logic [IW-1:0] wb_row, wr_off;
    logic [DW-1:0] wb_val, bank_rd;
    logic [DW-1:0] opnd;
    logic [2*DW-1:0] x_lat;

    ssc_sequencer #(.N(N)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wb_final(wb_final),
        .busy(busy), .accept(accept), .iss_v(iss_v), .iss_row(iss_row),
        .iss_col(iss_col), .iss_first(iss_first), .iss_last(iss_last)
    );

    assign coef_addr = CAW'(iss_row) * CAW'(N + 2) + CAW'(iss_col);

    always_comb begin
        if (iss_col < IW'(N))       opnd = bank_rd;
        else if (iss_col == IW'(N)) opnd = x_lat[DW-1:0];
        else                        opnd = x_lat[2*DW-1:DW];
    end

    ssc_mac_pipe #(.N(N), .DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)) i_mac (
        .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_row(iss_row),
        .iss_first(iss_first), .iss_last(iss_last),
        .coef($signed(coef_data)), .opnd($signed(opnd)),
        .wb_v(wb_v), .wb_row(wb_row), .wb_val(wb_val)
    );

    assign wb_final = wb_v && (wb_row == LASTI);
    assign wr_off   = wb_row - IW'(2);

    ssc_state_banks #(.N(N), .DW(DW)) i_banks (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(iss_col[SW-1:0]), .rd_data(bank_rd),
        .wr_en(wb_v && (wb_row >= IW'(2))), .wr_idx(wr_off[SW-1:0]),
        .wr_data(wb_val), .flip(wb_final),
        .act_bank(act_bank), .state_flat(state_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_lat   <= '0;
            y_out   <= '0;
            done    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (accept) x_lat <= x_in;
            if (wb_v && (wb_row == IW'(0))) y_out[DW-1:0]    <= wb_val;
            if (wb_v && (wb_row == IW'(1))) y_out[2*DW-1:DW] <= wb_val;
            done <= wb_final;
            if (accept)           overrun <= 1'b0;
            else if (start && busy) overrun <= 1'b1;
        end
    end

    // step-length counter used only by the checks below
    logic [$clog2(LATENCY + 2)-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_cnt <= '0;
        else if (accept) lat_cnt <= '0;
        else if (busy)   lat_cnt <= lat_cnt + 1'b1;
    end

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == ($clog2(LATENCY + 2))'(LATENCY)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> overrun);

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !overrun);
endmodule

// File: tb/test_ssc_engine.sv
module test_ssc_engine;
    localparam int N    = 4;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int AW   = 40;
    localparam int FRAC = 8;
    localparam int K    = N + 2;
    localparam int CAW  = $clog2(K * K);
    localparam int LAT  = K * K + 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2*DW-1:0] x_in = '0;
    logic [CAW-1:0]  coef_addr;
    logic [CW-1:0]   coef_data;
    logic [2*DW-1:0] y_out;
    logic [N*DW-1:0] state_out;
    logic            done, overrun;

    logic signed [CW-1:0] cf [K*K];
    longint ms [N];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign coef_data = cf[coef_addr];

    ssc_engine #(.N(N), .DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)) i_ssc_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .coef_addr(coef_addr), .coef_data(coef_data), .y_out(y_out),
        .state_out(state_out), .done(done), .overrun(overrun)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sval(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint row_val(input int r, input longint xa, input longint xb);
        longint acc = 0;
        longint sh;
        for (int c = 0; c < K; c++) begin
            longint op = (c < N) ? ms[c] : ((c == N) ? xa : xb);
            acc += longint'(cf[r*K + c]) * op;
        end
        sh = acc >>> FRAC;
        if (sh > 32767)  sh = 32767;
        if (sh < -32768) sh = -32768;
        return sh;
    endfunction

    // one step; caller stands at a negedge
    task automatic run_step(input longint xa, input longint xb, input bit ov_inj,
                            input bit xchg, input bit tail, input string req);
        longint ey [2];
        longint es [N];
        int cnt = 0;
        for (int r = 0; r < 2; r++) ey[r] = row_val(r, xa, xb);
        for (int i = 0; i < N; i++) es[i] = row_val(i + 2, xa, xb);
        x_in  = {DW'(xb), DW'(xa)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cnt < 2000) begin
            @(negedge clk);
            cnt++;
            if (xchg && cnt == 3) x_in = {16'sd9999, -16'sd7777};
            if (ov_inj && cnt == 5) start = 1'b1;
            if (ov_inj && cnt == 6) start = 1'b0;
            if (cnt == 12)
                for (int i = 0; i < N; i++)
                    chk("R6 state held mid-step", sval(state_out[i*DW +: DW]), ms[i]);
        end
        chk({"R4 latency ", req}, cnt, LAT);
        chk({"R1 y0 ", req}, sval(y_out[DW-1:0]), ey[0]);
        chk({"R1 y1 ", req}, sval(y_out[2*DW-1:DW]), ey[1]);
        for (int i = 0; i < N; i++) begin
            chk({"R1 R5 next state ", req}, sval(state_out[i*DW +: DW]), es[i]);
            ms[i] = es[i];
        end
        chk({"R7 overrun flag ", req}, longint'(overrun), longint'(ov_inj));
        if (tail) begin
            @(negedge clk);
            chk("R5 done single pulse", longint'(done), 0);
        end
    endtask

    task automatic t_reset();
        chk("R8 y after reset", longint'(y_out), 0);
        chk("R8 state after reset", longint'(state_out), 0);
        chk("R8 done after reset", longint'(done), 0);
        chk("R8 overrun after reset", longint'(overrun), 0);
    endtask

    task automatic t_dense();
        for (int k = 0; k < K*K; k++) cf[k] = CW'(((k * 37) % 181) - 90);
        run_step(1000, -500, 1'b0, 1'b0, 1'b1, "dense a");
        run_step(-1200, 800, 1'b0, 1'b0, 1'b1, "dense b");
        run_step(300, 3000, 1'b0, 1'b0, 1'b1, "dense c");
    endtask

    task automatic t_pre_update();
        longint old0;
        for (int k = 0; k < K*K; k++) cf[k] = '0;
        cf[0]     = 16'sd256;   // y0 = S[0]
        cf[2*K]   = 16'sd512;   // S'[0] = 2*S[0] + x0
        cf[2*K+N] = 16'sd256;
        old0 = ms[0];
        run_step(40, 0, 1'b0, 1'b0, 1'b1, "pre-update");
        chk("R3 y0 equals old S0", sval(y_out[DW-1:0]), old0);
    endtask

    task automatic t_arith();
        for (int k = 0; k < K*K; k++) cf[k] = '0;
        cf[N]     = 16'sd1;     // y0 = x0/256, floor
        cf[K+N+1] = 16'sh7F00;  // y1 = 127*x1, saturates
        run_step(-1, 30000, 1'b0, 1'b0, 1'b1, "arith pos");
        chk("R2 floor of -1/256", sval(y_out[DW-1:0]), -1);
        chk("R2 positive clamp", sval(y_out[2*DW-1:DW]), 32767);
        run_step(255, -30000, 1'b0, 1'b0, 1'b1, "arith neg");
        chk("R2 255/256 floors to 0", sval(y_out[DW-1:0]), 0);
        chk("R2 negative clamp", sval(y_out[2*DW-1:DW]), -32768);
    endtask

    task automatic t_overrun();
        for (int k = 0; k < K*K; k++) cf[k] = CW'(((k * 53) % 97) - 48);
        run_step(700, -900, 1'b1, 1'b0, 1'b1, "overrun ignored");
        run_step(100, 200, 1'b0, 1'b0, 1'b1, "R7 clear on accept");
    endtask

    task automatic t_xhold();
        run_step(-2500, 1500, 1'b0, 1'b1, 1'b1, "R9 x held");
    endtask

    task automatic t_back2back();
        run_step(50, -60, 1'b0, 1'b0, 1'b0, "R10 first");
        run_step(-70, 80, 1'b0, 1'b0, 1'b1, "R10 second");
    endtask

    initial begin
        for (int k = 0; k < K*K; k++) cf[k] = '0;
        for (int i = 0; i < N; i++) ms[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dense();
        t_pre_update();
        t_arith();
        t_overrun();
        t_xhold();
        t_back2back();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule